// File: doc/BRIEF.md
# Programmable Clock Divider Bank

A bank of integer clock dividers fed from the PLL output clock, which is also the block's own clock. Each channel turns a source event stream into a divided clock-enable strobe: one single-cycle pulse on `div_stb[i]` per output period. The source is either every PLL clock cycle or, when selected, the cycles in which the pre-PLL reference pulse `ref_tick` is high. `ref_tick` is already synchronised to the PLL clock.

Software programs each channel through a plain register port. A write to a channel's control register only updates a shadow copy. A GO command captures every shadow together. Each channel then moves to its new setting at the end of its current output period, so no shortened period appears. A busy flag in the status register stays high until the last channel has switched.

The register port has no handshake. A write takes effect on the rising clock edge at which `reg_we` is high. `reg_rdata` is a combinational view of the register that `reg_addr` selects.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, every control register reads 0 and the status busy bit reads 0. Every channel is disabled and sourced from the PLL, so each `div_stb` bit is high on every cycle.
- R2: The control register of channel i sits at address i. Its bits [RATIO_W-1:0] hold the ratio r and bit RATIO_W is the enable bit. With enable set, the channel strobes once every r+1 source events. Ratios run from 0 to 2^RATIO_W-1.
- R3: With the enable bit clear, a channel strobes on every source event, whatever its ratio field holds.
- R4: A write to a control register leaves the channel's output unchanged until a GO command is accepted. Reading the register returns the value last written, in its low RATIO_W+2 bits.
- R5: A write with bit 0 set to the command address NCH, made while the block is idle, is a GO command. It captures all shadow registers at once. Status bit 0 at address NCH+1 reads 1 from the next cycle until every channel has switched, and reads 0 after that.
- R6: Bit RATIO_W+1 of a control register selects the source. At 1, the channel's source events are the cycles in which `ref_tick` is high. At 0, the source is every PLL cycle.
- R7: A GO written while busy reads 1 is ignored. Channels finish switching to the values captured by the earlier GO, and shadow values written since then stay staged.
- R8: A channel switches only at the end of a full output period. Every interval between its strobes while a switch is in progress equals either the old period or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock; clocks the whole block |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Pre-PLL reference event, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: channels 0..NCH-1, command NCH, status NCH+1 |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for the register at reg_addr |
| div_stb | output | NCH | Divided clock-enable strobes, one bit per channel |

## Verification
Four properties are checked on every cycle:
- A channel's count never passes its limit.
- A disabled channel strobes on every source event.
- An accepted GO raises busy, and a GO written while busy leaves the captured settings untouched.
- A channel leaves the pending state only in a cycle where it strobed.

Other behaviour shows only in the bench's scenarios, which measure strobe intervals against arithmetic expectations. These cover:
- the divide factor for every ratio;
- the reference-sourced periods;
- a shadow write that does not change the output;
- the rejected second GO;
- the absence of short periods when GO lands at each possible phase of the old period.

// File: rtl/clkdiv_bank_pkg.sv
package clkdiv_bank_pkg;
  // bit positions inside the command and status registers
  localparam int GO_BIT   = 0;
  localparam int BUSY_BIT = 0;

  // field positions inside a channel control register
  function automatic int en_pos(int ratio_w);
    return ratio_w;
  endfunction

  function automatic int src_pos(int ratio_w);
    return ratio_w + 1;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_bank_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int RATIO_W = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  localparam int CW     = RATIO_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NCH-1:0]           taken,
  output logic [DATA_W-1:0]        rdata,
  output logic [NCH-1:0][CW-1:0]   pend_cfg,
  output logic [NCH-1:0]           pend,
  output logic                     busy
);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(NCH);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NCH + 1);

  logic [NCH-1:0][CW-1:0] shadow_q;
  logic [NCH-1:0][CW-1:0] pcfg_q;
  logic [NCH-1:0]         pend_q;
  logic                   go_wr;
  logic                   go_acc;

  assign busy   = |pend_q;
  assign go_wr  = we && (addr == CMD_A) && wdata[GO_BIT];
  assign go_acc = go_wr && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (we && addr == ADDR_W'(i)) shadow_q[i] <= wdata[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcfg_q <= '0;
      pend_q <= '0;
    end else if (go_acc) begin
      pcfg_q <= shadow_q;
      pend_q <= '1;
    end else begin
      pend_q <= pend_q & ~taken;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(i)) rdata[CW-1:0] = shadow_q[i];
    end
    if (addr == STAT_A) rdata[BUSY_BIT] = busy;
  end

  assign pend_cfg = pcfg_q;
  assign pend     = pend_q;

  // R5
  go_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_acc |=> busy);

  // R7
  go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && busy) |=> $stable(pcfg_q));
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
  import clkdiv_bank_pkg::*;
#(
  parameter int RATIO_W = 4,
  localparam int CW     = RATIO_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          pend_i,
  input  logic [CW-1:0] cfg_i,
  output logic          stb_o,
  output logic          take_o
);
  logic [CW-1:0]      act_q;
  logic [RATIO_W-1:0] cnt_q;
  logic               act_en;
  logic               act_src;
  logic [RATIO_W-1:0] lim;
  logic               ev;
  logic               hit;

  assign act_en  = act_q[en_pos(RATIO_W)];
  assign act_src = act_q[src_pos(RATIO_W)];
  assign lim     = act_en ? act_q[RATIO_W-1:0] : '0;
  assign ev      = act_src ? ref_tick : 1'b1;
  assign hit     = ev && (cnt_q == lim);
  assign stb_o   = hit;
  assign take_o  = hit && pend_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (take_o) begin
      act_q <= cfg_i;
      cnt_q <= '0;
    end else if (hit) begin
      cnt_q <= '0;
    end else if (ev) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_en && ev) |-> stb_o);
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_bank_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int RATIO_W  = 4,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = $clog2(NCH + 2),
  localparam int CW      = RATIO_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    div_stb
);
  logic [NCH-1:0][CW-1:0] pend_cfg;
  logic [NCH-1:0]         pend;
  logic [NCH-1:0]         taken;
  logic                   busy;

  clkdiv_regs #(
    .NCH(NCH), .RATIO_W(RATIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .taken(taken), .rdata(reg_rdata),
    .pend_cfg(pend_cfg), .pend(pend), .busy(busy)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    clkdiv_chan #(.RATIO_W(RATIO_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .pend_i(pend[g]), .cfg_i(pend_cfg[g]),
      .stb_o(div_stb[g]), .take_o(taken[g])
    );

    // R8
    switch_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[g]) |-> $past(div_stb[g]));
  end
endmodule

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
  localparam int NCH = 4;
  localparam int RW  = 4;
  localparam int DW  = 8;
  localparam int AW  = $clog2(NCH + 2);
  localparam int CMD = NCH;
  localparam int STA = NCH + 1;
  localparam int REFP = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic ref_tick = 0;
  logic reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NCH-1:0] div_stb;
  int phase = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    phase    <= (phase == REFP - 1) ? 0 : phase + 1;
    ref_tick <= (phase == REFP - 2);
  end

  clkdiv_bank #(.NCH(NCH), .RATIO_W(RW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .div_stb(div_stb)
  );

  function automatic int ctl(int src, int en, int r);
    return (src << (RW + 1)) | (en << RW) | r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_now(int a, output int v);
    reg_addr = AW'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    rd_now(a, v);
  endtask

  task automatic wait_stb(int ch);
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (div_stb[ch]) return;
    end
  endtask

  task automatic interval(int ch, output int n);
    wait_stb(ch);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      n++;
      if (div_stb[ch]) return;
    end
  endtask

  task automatic wait_idle(output int st);
    for (int k = 0; k < 2000; k++) begin
      rd(STA, st);
      if ((st & 1) == 0) return;
    end
  endtask

  task automatic go_idle();
    int st;
    wr(CMD, 1);
    wait_idle(st);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, n, bad;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int c = 0; c < NCH; c++) begin
      rd(c, v); check("R1 ctrl readback", v, 0);
    end
    rd(STA, v); check("R1 busy", v & 1, 0);
    for (int c = 0; c < NCH; c++) begin
      interval(c, n); check("R1 passthrough", n, 1);
    end

    // R2: full ratio sweep, two channels switched by one GO
    for (int r = 0; r < (1 << RW); r++) begin
      wr(0, ctl(0, 1, r));
      wr(3, ctl(0, 1, (1 << RW) - 1 - r));
      go_idle();
      interval(0, n); check("R2 ch0 period", n, r + 1);
      interval(3, n); check("R2 ch3 period", n, (1 << RW) - r);
    end
    wr(3, 0);

    // R3: disabled channel ignores ratio
    for (int r = 0; r < (1 << RW); r += 5) begin
      wr(1, ctl(0, 0, r)); go_idle();
      interval(1, n); check("R3 disabled pll", n, 1);
    end
    wr(1, ctl(1, 0, 9)); go_idle();
    interval(1, n); check("R6 disabled ref", n, REFP);

    // R6: reference source sweep
    for (int r = 0; r < (1 << RW); r++) begin
      wr(1, ctl(1, 1, r)); go_idle();
      interval(1, n); check("R6 ref period", n, REFP * (r + 1));
    end
    wr(1, 0); go_idle();

    // R4: staged write without GO
    wr(0, ctl(0, 1, 4)); go_idle();
    wr(0, ctl(0, 1, 9));
    repeat (30) @(negedge clk);
    interval(0, n); check("R4 unchanged before GO", n, 5);
    rd(0, v); check("R4 shadow readback", v, ctl(0, 1, 9));

    // R5: busy raised by GO, then cleared
    wr(CMD, 1);
    rd_now(STA, v); check("R5 busy after GO", v & 1, 1);
    wait_idle(v); check("R5 busy clears", v & 1, 0);
    interval(0, n); check("R4 applied after GO", n, 10);

    // R8: switch at every phase, both directions
    for (int ph = 0; ph < 8; ph++) begin
      for (int dir = 0; dir < 2; dir++) begin
        int po, pn;
        po = dir ? 3 : 8; pn = dir ? 8 : 3;
        wr(0, ctl(0, 1, po - 1)); go_idle();
        wait_stb(0);
        repeat (ph) @(negedge clk);
        wr(0, ctl(0, 1, pn - 1));
        wr(CMD, 1);
        bad = 0;
        for (int k = 0; k < 6; k++) begin
          interval(0, n);
          if (n != po && n != pn) bad++;
        end
        check("R8 no short period", bad, 0);
        check("R8 final period", n, pn);
      end
    end

    // R7: GO during busy is ignored
    wr(2, ctl(1, 1, 15));
    wr(0, ctl(0, 1, 3));
    go_idle();
    wait_stb(2);
    wr(CMD, 1);
    rd_now(STA, v); check("R7 busy before second GO", v & 1, 1);
    wr(0, ctl(0, 1, 6));
    wr(CMD, 1);
    wait_idle(v);
    interval(0, n); check("R7 second GO ignored", n, 4);
    rd(0, v); check("R7 shadow kept", v, ctl(0, 1, 6));
    go_idle();
    interval(0, n); check("R7 later GO applies", n, 7);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule